// File: doc/BRIEF.md
# Input Change Interrupt Controller

This block watches a bank of general-purpose port pins. For each pin that is set up as an input, it notices a change of level and records it as a sticky flag in a status word. While a flag that has not yet been acknowledged is present and the global interrupt enable is on, it pulls an active-low, open-drain alert line toward the host. The bus interface beside it supplies two single-cycle strobes. One marks a read of the status word. The other marks a poll of the alert response address, 7'b0001100.

The raw pin levels are asynchronous, so a chain of synchronizer flops samples them first. A change is then found by comparing each synchronized level with the one from the previous cycle. When fan mode is selected, the top pins serve as fan-control outputs, and their changes are ignored.

A read of the status word empties all flags together and releases the alert. A change seen in the same cycle as the read is kept. A poll of the alert response address releases only the alert and leaves the flags unchanged. The alert then stays released until a fresh flag is raised.

Top module: `pin_change_irq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `status` is 8'h00 and `alert_pull` is 0 (alert line released).
- R2: When pin n is an input (`dir_out[n]`=0), a level change present on `pin_async[n]` before rising edge k sets `status[n]` after edge k+2 and not earlier.
- R3: A pin with `dir_out[n]`=1 (output) never sets its status bit, whatever its level does.
- R4: While `fan_mode`=1, changes on the upper four pins (bits 7 to 4) set no status bit and raise no alert.
- R5: A status bit, once set, stays set until a status read, even if the pin returns to its earlier level.
- R6: A cycle with `stat_rd`=1 clears every status bit and releases the alert. A change detected in that same cycle is kept, so its bit and the alert are set after the read.
- R7: `alert_pull`=1 (pull the line low) exactly when `irq_en`=1 and a flag has been raised since the last status read or alert-response poll. With `irq_en`=0 the line is released, but the flags are still recorded.
- R8: A cycle with `ara_hit`=1 releases the alert and leaves `status` unchanged. The alert stays released until a new change is detected.
- R9: Levels present on the pins during reset do not produce flags. Detection starts only once the synchronizer and the previous-level register hold real samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_async | input | 8 | Raw pin levels, not yet synchronized |
| dir_out | input | 8 | Direction per pin, 1 = output, 0 = input |
| irq_en | input | 1 | Global interrupt enable |
| fan_mode | input | 1 | 1 = upper four pins are fan outputs |
| stat_rd | input | 1 | One-cycle strobe: host read of the status word |
| ara_hit | input | 1 | One-cycle strobe: host polled the alert response address |
| status | output | 8 | Sticky change flags, one per pin |
| alert_pull | output | 1 | 1 = drive the open-drain alert line low |

## Verification
Several rules are checked by assertions in every cycle. Output pins and masked fan pins never gain a new flag. Flags stay set when no read occurs. A read with no coincident change leaves the word empty. An alert-response poll with no new change releases the line. The alert is never active with an empty status word, and nothing is flagged before detection is armed. Other behaviour can only be shown by the bench's scenarios: the exact two-edge latency from pin to flag, a change kept in the same cycle as a read, the alert staying released after a poll until a new change arrives, and the recording of flags while interrupts are disabled.

// File: rtl/pci_pkg.sv
package pci_pkg;

  // Mask with the top nfan bits set, in a word of the given width.
  function automatic logic [31:0] fan_mask(int width, int nfan);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < width && i >= width - nfan) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Pins allowed to report a change: inputs, minus fan pins in fan mode.
  function automatic logic [31:0] eligible(logic [31:0] dir, logic fan,
                                           logic [31:0] fmask);
    return ~dir & ~(fan ? fmask : 32'h0);
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/change_detect.sv
module change_detect #(
  parameter int W        = 8,
  parameter int FAN_PINS = 4,
  parameter int STAGES   = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] dir_out,
  input  logic         fan_mode,
  output logic [W-1:0] chg_vec,
  output logic         armed
);

  localparam int FILL_MAX = STAGES + 1;
  localparam int CW       = $clog2(FILL_MAX + 1);
  localparam logic [W-1:0] FAN_M = W'(pci_pkg::fan_mask(W, FAN_PINS));

  logic [W-1:0]  prev_q;
  logic [CW-1:0] fill_q;
  logic [W-1:0]  elig;
  logic [W-1:0]  diff;

  assign armed = (fill_q == CW'(FILL_MAX));
  assign elig  = W'(pci_pkg::eligible(32'(dir_out), fan_mode, 32'(FAN_M)));
  assign diff  = lvl ^ prev_q;
  assign chg_vec = armed ? (diff & elig) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      fill_q <= '0;
    end else begin
      prev_q <= lvl;
      if (!armed) fill_q <= fill_q + CW'(1);
    end
  end

  // R9: once armed, detection never disarms until reset
  assert_stays_armed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

endmodule

// File: rtl/status_flags.sv
module status_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] chg_vec,
  input  logic         stat_rd,
  output logic [W-1:0] status
);

  logic [W-1:0] status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status_q <= '0;
    else if (stat_rd) status_q <= chg_vec;
    else              status_q <= status_q | chg_vec;
  end

  assign status = status_q;

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_read_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && chg_vec == '0) |=> (status_q == '0));

endmodule

// File: rtl/alert_ctrl.sv
module alert_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic new_evt,
  input  logic stat_rd,
  input  logic ara_hit,
  input  logic irq_en,
  output logic alert_pull
);

  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pend_q <= 1'b0;
    else if (stat_rd || ara_hit) pend_q <= new_evt;
    else if (new_evt)           pend_q <= 1'b1;
  end

  assign alert_pull = irq_en & pend_q;

  assert_poll_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ara_hit && !new_evt) |=> !pend_q);

  assert_quiet_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !new_evt) |=> !pend_q);

endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int W        = 8,
  parameter int FAN_PINS = 4,
  parameter int STAGES   = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_async,
  input  logic [W-1:0] dir_out,
  input  logic         irq_en,
  input  logic         fan_mode,
  input  logic         stat_rd,
  input  logic         ara_hit,
  output logic [W-1:0] status,
  output logic         alert_pull
);

  localparam logic [W-1:0] FAN_M = W'(pci_pkg::fan_mask(W, FAN_PINS));

  logic [W-1:0] lvl_sync;
  logic [W-1:0] chg_vec;
  logic         armed_w;
  logic         new_evt;

  pin_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_async), .q_sync(lvl_sync));

  change_detect #(.W(W), .FAN_PINS(FAN_PINS), .STAGES(STAGES)) u_det (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_sync), .dir_out(dir_out),
    .fan_mode(fan_mode), .chg_vec(chg_vec), .armed(armed_w));

  status_flags #(.W(W)) u_flags (
    .clk(clk), .rst_n(rst_n), .chg_vec(chg_vec), .stat_rd(stat_rd),
    .status(status));

  assign new_evt = |chg_vec;

  alert_ctrl u_alert (
    .clk(clk), .rst_n(rst_n), .new_evt(new_evt), .stat_rd(stat_rd),
    .ara_hit(ara_hit), .irq_en(irq_en), .alert_pull(alert_pull));

  assert_out_pins_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status) & $past(dir_out)) == '0));

  assert_fan_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fan_mode |=> ((status & ~$past(status) & FAN_M) == '0));

  assert_alert_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alert_pull |-> (status != '0));

  assert_unarmed_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_w |-> (status == '0 && !alert_pull));

endmodule

// File: tb/tb_pin_change_irq.sv
`timescale 1ns/1ps
module tb_pin_change_irq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pin_async, dir_out;
  logic       irq_en, fan_mode, stat_rd, ara_hit;
  logic [7:0] status;
  logic       alert_pull;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pin_change_irq dut (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .dir_out(dir_out),
    .irq_en(irq_en), .fan_mode(fan_mode), .stat_rd(stat_rd),
    .ara_hit(ara_hit), .status(status), .alert_pull(alert_pull));

  // {pins, dir, fan, en, rd, exp_status, exp_alert}
  localparam int NV = 11;
  localparam logic [27:0] VECS [NV] = '{
    {8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0}, // idle
    {8'h01, 8'h00, 1'b0, 1'b1, 1'b1, 8'h01, 1'b1}, // R2 bit0
    {8'h01, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0}, // R6 cleared
    {8'h81, 8'h80, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0}, // R3 output pin
    {8'hF1, 8'h80, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0}, // R4 fan pins
    {8'hF3, 8'h80, 1'b1, 1'b1, 1'b1, 8'h02, 1'b1}, // R4 low pin still live
    {8'hF2, 8'h80, 1'b1, 1'b0, 1'b0, 8'h01, 1'b0}, // R7 disabled
    {8'hF2, 8'h80, 1'b1, 1'b1, 1'b1, 8'h01, 1'b1}, // R7 enabled
    {8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 8'hF2, 1'b1}, // R2 many bits
    {8'hF2, 8'h00, 1'b0, 1'b1, 1'b1, 8'hF2, 1'b1}, // R5 sticky
    {8'hF2, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0}  // R6 after read
  };

  task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s status act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic chk1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s alert act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rd();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; pin_async = 8'hFF; dir_out = 8'h00;
    irq_en = 1'b1; fan_mode = 1'b0; stat_rd = 1'b0; ara_hit = 1'b0;
    cycles(3);
    chk8("R1 in reset", status, 8'h00);
    chk1("R1 in reset", alert_pull, 1'b0);
    rst_n = 1'b1;
    cycles(1);
    chk8("R1 after reset", status, 8'h00);
    chk1("R1 after reset", alert_pull, 1'b0);
    cycles(6);
    chk8("R9 reset levels", status, 8'h00);
    chk1("R9 reset levels", alert_pull, 1'b0);

    pin_async = 8'h00;
    cycles(4);
    chk8("R2 all fall", status, 8'hFF);
    chk1("R7 all fall", alert_pull, 1'b1);
    pulse_rd();

    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      v = VECS[i];
      pin_async = v[27:20]; dir_out = v[19:12];
      fan_mode = v[11]; irq_en = v[10];
      cycles(4);
      chk8($sformatf("table %0d R2 R3 R4 R5 R6 R7", i), status, v[8:1]);
      chk1($sformatf("table %0d R2 R3 R4 R5 R6 R7", i), alert_pull, v[0]);
      if (v[9]) pulse_rd();
    end

    // R2 latency: change before edge k visible after edge k+2
    pin_async = 8'hF6;
    cycles(1); chk8("R2 after k", status, 8'h00);
    cycles(1); chk8("R2 after k+1", status, 8'h00);
    cycles(1); chk8("R2 after k+2", status, 8'h04);
    chk1("R2 alert", alert_pull, 1'b1);

    // R6 change coincident with read is kept
    pin_async = 8'hFE;
    cycles(2);
    stat_rd = 1'b1;
    cycles(1);
    stat_rd = 1'b0;
    chk8("R6 coincident", status, 8'h08);
    chk1("R6 coincident", alert_pull, 1'b1);

    // R8 alert-response poll
    ara_hit = 1'b1;
    cycles(1);
    ara_hit = 1'b0;
    chk1("R8 poll releases", alert_pull, 1'b0);
    chk8("R8 status kept", status, 8'h08);
    cycles(3);
    chk1("R8 stays released", alert_pull, 1'b0);
    pin_async = 8'hFC;
    cycles(4);
    chk8("R8 new flag", status, 8'h0A);
    chk1("R8 new flag", alert_pull, 1'b1);

    // R7 disabling releases line, flags remain
    irq_en = 1'b0;
    cycles(1);
    chk1("R7 disable", alert_pull, 1'b0);
    chk8("R7 flags kept", status, 8'h0A);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule